// File: doc/BRIEF.md
# Transmit Clock Loss Guard with Receive-Clock Failover

This block watches the transmit reference clock from a free-running monitor clock and decides when that reference has stopped toggling. Each detection raises a sticky loss flag that the host clears with a one-cycle pulse. The flag is raised on every detection, whether or not automatic failover is enabled.

When the failover control is high and the reference is declared lost, the block hands the transmit clock over to the recovered receive clock through a glitch-free switch. It also replaces the transmit data with an alarm indication signal, which here is a stream of all ones. When the reference toggles steadily again, the block returns to it and releases the data. When the failover control is low, detection only sets the flag. The clock and data paths are left alone.

The monitor clock must run more than twice as fast as the reference clock. The reference half period must be shorter than half the loss window. Switching to the receive clock only happens after the reference has stopped, which is why the reference-side enable may be cleared asynchronously.

Top module: `txclk_guard`

## Requirements
- R1: After a synchronous reset (rst_n low for at least 4 monitor cycles, with both transmit-side clocks running), loss_status and on_rx read 0 and clk_out follows ref_clk.
- R2: A reference that shows no edge for 16 consecutive monitor cycles (after a 2-stage synchroniser) is declared lost and sets loss_status. A gap of 10 monitor cycles does not set it.
- R3: loss_status is set on every loss declaration, regardless of failover_en. It stays set until a status_clr pulse, and a declaration in the same cycle as a clear wins. A clear while the reference stays lost leaves the flag at 0, because only a new declaration sets it.
- R4: With failover_en low, a loss changes nothing but loss_status: on_rx stays 0, data_out equals data_in and clk_out keeps following ref_clk.
- R5: With failover_en high, a loss drives on_rx to 1, and after the handover clk_out follows rx_clk.
- R6: While on_rx is 1, every bit of data_out is 1 (AIS).
- R7: The two clock enables are never both active. The reference enable drops on a reference falling edge, or at once when failover takes effect. The receive enable rises only after the reference enable is seen low. This holds whether the reference stopped high or low.
- R8: A lost reference counts as restored only after 16 consecutive monitor cycles in which its edge gap stays under 8 cycles. A short burst of one or two edges does not restore it. Once it is restored, on_rx returns to 0 and clk_out follows ref_clk again.
- R9: Restoring the reference does not clear loss_status.
- R10: Dropping failover_en while the reference is lost returns on_rx to 0 on the next cycle and removes AIS.
- R11: While on_rx is 0, data_out equals data_in for every pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock; all control state lives here |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Transmit reference clock under watch |
| rx_clk | input | 1 | Recovered receive clock used as the fallback |
| failover_en | input | 1 | 1 = switch to rx_clk and send AIS on loss |
| data_in | input | DATA_W (4) | Transmit data from upstream |
| status_clr | input | 1 | One-cycle pulse that clears loss_status |
| clk_out | output | 1 | Selected transmit clock |
| data_out | output | DATA_W (4) | Transmit data, or all ones while failed over |
| on_rx | output | 1 | 1 while failover is in effect |
| loss_status | output | 1 | Sticky loss flag |

## Verification
The bench stops the reference once low and once high. A switch that waits for a falling edge of a dead reference would stay stuck on a high clock instead of following rx_clk. It clears the flag while the reference is still dead, to catch a flag built as a level rather than an event, and it checks the flag after recovery, to catch a recovery path that wipes the status. A one-pulse burst on the dead reference must not restore it; a detector that counts only edges would switch back too early. Dropping failover_en mid-loss must release the data and the clock selection at once.

// File: rtl/txg_pkg.sv
// Package: shared defaults for the transmit clock guard.
// Assumes nothing beyond the parameters being positive.
package txg_pkg;
    localparam int LOSS_CYCLES_DEF  = 16;
    localparam int HEAL_CYCLES_DEF  = 16;
    localparam int SYNC_STAGES_DEF  = 2;
    localparam int DATA_W_DEF       = 4;

    // Width of a counter that must hold values 0..n.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/txg_sync.sv
// Multi-bit level synchroniser: a chain of STAGES flops per bit.
// Assumes each bit is an independent level (no bus coherency) and STAGES >= 2.
module txg_sync #(
    parameter int W      = 1,
    parameter int STAGES = txg_pkg::SYNC_STAGES_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CW = W * STAGES;

    logic [CW-1:0] chain;

    // Shift the sampled input through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CW-W-1:0], d};
    end

    assign q = chain[CW-1 -: W];
endmodule

// File: rtl/txg_edge_watch.sv
// Reference activity watcher in the monitor clock domain.
// Declares loss after LOSS_CYCLES cycles without a synchronised edge, and
// restores after HEAL_CYCLES consecutive cycles whose edge gap stays below
// LOSS_CYCLES/2. Assumes mon_clk is more than twice as fast as ref_clk.
module txg_edge_watch #(
    parameter int LOSS_CYCLES = txg_pkg::LOSS_CYCLES_DEF,
    parameter int HEAL_CYCLES = txg_pkg::HEAL_CYCLES_DEF,
    parameter int SYNC_STAGES = txg_pkg::SYNC_STAGES_DEF
) (
    input  logic mon_clk,
    input  logic rst_n,
    input  logic ref_clk,
    output logic lost,
    output logic loss_evt
);
    localparam int HEAL_GAP = (LOSS_CYCLES / 2 < 1) ? 1 : LOSS_CYCLES / 2;
    localparam int IW       = txg_pkg::cnt_w(LOSS_CYCLES);
    localparam int HW       = txg_pkg::cnt_w(HEAL_CYCLES);

    logic          ref_s;
    logic          ref_d;
    logic          ref_edge;
    logic [IW-1:0] idle;
    logic [HW-1:0] heal;
    logic          idle_full;
    logic          gap_ok;

    txg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ref_sync (
        .clk   (mon_clk),
        .rst_n (rst_n),
        .d     (ref_clk),
        .q     (ref_s)
    );

    assign ref_edge  = ref_s ^ ref_d;
    assign idle_full = (idle == IW'(LOSS_CYCLES));
    assign gap_ok    = (idle < IW'(HEAL_GAP));

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) ref_d <= 1'b0;
        else        ref_d <= ref_s;
    end

    // Count cycles since the last edge, saturating at the loss limit.
    always_ff @(posedge mon_clk) begin
        if (!rst_n)        idle <= '0;
        else if (ref_edge) idle <= '0;
        else if (!idle_full) idle <= idle + 1'b1;
    end

    // Declare loss on a full idle window; restore after a steady healing run.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            lost     <= 1'b0;
            heal     <= '0;
            loss_evt <= 1'b0;
        end else if (!lost) begin
            heal     <= '0;
            lost     <= idle_full;
            loss_evt <= idle_full;
        end else begin
            loss_evt <= 1'b0;
            if (!gap_ok) begin
                heal <= '0;
            end else if (heal == HW'(HEAL_CYCLES - 1)) begin
                heal <= '0;
                lost <= 1'b0;
            end else begin
                heal <= heal + 1'b1;
            end
        end
    end
endmodule

// File: rtl/txg_clk_switch.sv
// Glitch-free two-source clock switch.
// Each source has an enable updated on that source's falling edge, allowed to
// rise only once the other enable is seen low through a synchroniser.
// sel_rx clears the reference enable at once: it is only raised after the
// reference has already stopped, so no short pulse can be cut.
module txg_clk_switch #(
    parameter int SYNC_STAGES = txg_pkg::SYNC_STAGES_DEF
) (
    input  logic rst_n,
    input  logic ref_clk,
    input  logic rx_clk,
    input  logic sel_rx,
    output logic en_ref,
    output logic en_rx,
    output logic clk_out
);
    logic ref_sel_s;
    logic ref_rxen_s;
    logic rx_sel_s;
    logic rx_refen_s;

    txg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ref_side (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     ({sel_rx, en_rx}),
        .q     ({ref_sel_s, ref_rxen_s})
    );

    txg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_rx_side (
        .clk   (rx_clk),
        .rst_n (rst_n),
        .d     ({sel_rx, en_ref}),
        .q     ({rx_sel_s, rx_refen_s})
    );

    // Reference enable: falls on a reference low phase or at once on failover.
    always_ff @(negedge ref_clk or posedge sel_rx) begin
        if (sel_rx)      en_ref <= 1'b0;
        else if (!rst_n) en_ref <= 1'b0;
        else             en_ref <= !ref_sel_s && !ref_rxen_s;
    end

    // Receive enable: rises only once the reference enable is seen low.
    always_ff @(negedge rx_clk) begin
        if (!rst_n) en_rx <= 1'b0;
        else        en_rx <= rx_sel_s && !rx_refen_s;
    end

    assign clk_out = (ref_clk & en_ref) | (rx_clk & en_rx);
endmodule

// File: rtl/txclk_guard.sv
// Top: transmit clock loss guard with optional failover to the receive clock.
// Keeps the sticky loss flag, the failover selection and the AIS data
// override in the monitor domain. Assumes rst_n is synchronous to mon_clk.
module txclk_guard #(
    parameter int DATA_W      = txg_pkg::DATA_W_DEF,
    parameter int LOSS_CYCLES = txg_pkg::LOSS_CYCLES_DEF,
    parameter int HEAL_CYCLES = txg_pkg::HEAL_CYCLES_DEF,
    parameter int SYNC_STAGES = txg_pkg::SYNC_STAGES_DEF
) (
    input  logic              mon_clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic              rx_clk,
    input  logic              failover_en,
    input  logic [DATA_W-1:0] data_in,
    input  logic              status_clr,
    output logic              clk_out,
    output logic [DATA_W-1:0] data_out,
    output logic              on_rx,
    output logic              loss_status
);
    logic lost;
    logic loss_evt;
    logic en_ref;
    logic en_rx;

    txg_edge_watch #(
        .LOSS_CYCLES (LOSS_CYCLES),
        .HEAL_CYCLES (HEAL_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_watch (
        .mon_clk  (mon_clk),
        .rst_n    (rst_n),
        .ref_clk  (ref_clk),
        .lost     (lost),
        .loss_evt (loss_evt)
    );

    txg_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
        .rst_n   (rst_n),
        .ref_clk (ref_clk),
        .rx_clk  (rx_clk),
        .sel_rx  (on_rx),
        .en_ref  (en_ref),
        .en_rx   (en_rx),
        .clk_out (clk_out)
    );

    // Sticky flag: a new declaration wins over a host clear.
    always_ff @(posedge mon_clk) begin
        if (!rst_n)          loss_status <= 1'b0;
        else if (loss_evt)   loss_status <= 1'b1;
        else if (status_clr) loss_status <= 1'b0;
    end

    // Failover is in effect only while lost and enabled.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) on_rx <= 1'b0;
        else        on_rx <= lost && failover_en;
    end

    // AIS override replaces the data with all ones during failover.
    always_comb begin
        data_out = on_rx ? {DATA_W{1'b1}} : data_in;
    end
endmodule

// File: rtl/txclk_guard_chk.sv
// Checker bound to txclk_guard: temporal rules on the monitor clock.
module txclk_guard_chk #(
    parameter int DATA_W = txg_pkg::DATA_W_DEF
) (
    input logic              mon_clk,
    input logic              rst_n,
    input logic              failover_en,
    input logic              status_clr,
    input logic [DATA_W-1:0] data_in,
    input logic [DATA_W-1:0] data_out,
    input logic              on_rx,
    input logic              loss_status,
    input logic              lost,
    input logic              en_ref,
    input logic              en_rx
);
    AST_SET_ON_LOSS: assert property (@(posedge mon_clk) disable iff (!rst_n)
        $rose(lost) |=> loss_status); // R2
    AST_FLAG_STICKY: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (loss_status && !status_clr) |=> loss_status); // R3
    AST_NO_SWITCH_OFF: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !failover_en |=> !on_rx); // R4
    AST_AIS_ONES: assert property (@(posedge mon_clk) disable iff (!rst_n)
        on_rx |-> (data_out == {DATA_W{1'b1}})); // R6
    AST_ONE_ENABLE: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !(en_ref && en_rx)); // R7
    AST_DROP_RELEASE: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (on_rx && !failover_en) |=> !on_rx); // R10
    AST_PASS_DATA: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !on_rx |-> (data_out == data_in)); // R11
endmodule

bind txclk_guard txclk_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .mon_clk     (mon_clk),
    .rst_n       (rst_n),
    .failover_en (failover_en),
    .status_clr  (status_clr),
    .data_in     (data_in),
    .data_out    (data_out),
    .on_rx       (on_rx),
    .loss_status (loss_status),
    .lost        (lost),
    .en_ref      (en_ref),
    .en_rx       (en_rx)
);

// File: tb/txclk_guard_test.sv
module txclk_guard_test;
    localparam int DW = 4;
    localparam int SIG_STATUS = 0;
    localparam int SIG_ONRX   = 1;
    localparam int SIG_DATA   = 2;
    localparam int SIG_CLKREF = 3;
    localparam int SIG_CLKRX  = 4;

    typedef struct {
        string       req;
        int          sig;
        logic [31:0] exp;
    } item_t;

    logic          mon_clk = 0;
    logic          rst_n = 0;
    logic          ref_clk = 0;
    logic          rx_clk = 0;
    logic          failover_en = 0;
    logic [DW-1:0] data_in = '0;
    logic          status_clr = 0;
    logic          clk_out;
    logic [DW-1:0] data_out;
    logic          on_rx;
    logic          loss_status;

    logic ref_run  = 1;
    logic ref_idle = 0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done     = 0;
    item_t exp_q[$];

    txclk_guard uut (
        .mon_clk     (mon_clk),
        .rst_n       (rst_n),
        .ref_clk     (ref_clk),
        .rx_clk      (rx_clk),
        .failover_en (failover_en),
        .data_in     (data_in),
        .status_clr  (status_clr),
        .clk_out     (clk_out),
        .data_out    (data_out),
        .on_rx       (on_rx),
        .loss_status (loss_status)
    );

    always #10 mon_clk = ~mon_clk;

    initial begin
        #5;
        forever begin
            #50;
            ref_clk = ref_run ? ~ref_clk : ref_idle;
        end
    end

    initial begin
        #7;
        forever #65 rx_clk = ~rx_clk;
    end

    // Monitor: pops the expected item and compares it on the falling edge.
    always @(negedge mon_clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            case (it.sig)
                SIG_STATUS: act = 32'(loss_status);
                SIG_ONRX:   act = 32'(on_rx);
                SIG_DATA:   act = 32'(data_out);
                SIG_CLKREF: act = 32'(clk_out == ref_clk);
                default:    act = 32'(clk_out == rx_clk);
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s sig=%0d actual=%0h expected=%0h", it.req, it.sig, act, it.exp);
            end
        end
    end

    task automatic expect_now(input string req, input int sig, input logic [31:0] e);
        item_t it;
        it.req = req; it.sig = sig; it.exp = e;
        exp_q.push_back(it);
        @(negedge mon_clk);
        #1;
    endtask

    task automatic wait_mon(input int n);
        repeat (n) @(posedge mon_clk);
        #3;
    endtask

    task automatic clk_follows(input string req, input int sig);
        for (int i = 0; i < 6; i++) begin
            expect_now(req, sig, 1);
            wait_mon(3);
        end
    endtask

    task automatic pulse_clear();
        status_clr = 1;
        wait_mon(1);
        status_clr = 0;
        wait_mon(2);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        wait_mon(6);
        rst_n = 1;
        wait_mon(40);
        // R1: clean reset state
        expect_now("R1", SIG_STATUS, 0);
        expect_now("R1", SIG_ONRX, 0);
        clk_follows("R1", SIG_CLKREF);

        // R11: pass-through of several patterns
        failover_en = 1;
        data_in = 4'h5; wait_mon(1); expect_now("R11", SIG_DATA, 32'h5);
        data_in = 4'hA; wait_mon(1); expect_now("R11", SIG_DATA, 32'hA);
        data_in = 4'h0; wait_mon(1); expect_now("R11", SIG_DATA, 32'h0);

        // R2/R4: loss with failover disabled, reference stopped low
        failover_en = 0; data_in = 4'h6;
        ref_idle = 0; ref_run = 0;
        wait_mon(10);
        expect_now("R2", SIG_STATUS, 0);
        wait_mon(20);
        expect_now("R2", SIG_STATUS, 1);
        expect_now("R4", SIG_ONRX, 0);
        expect_now("R4", SIG_DATA, 32'h6);
        clk_follows("R4", SIG_CLKREF);

        // R3: clear while still lost leaves the flag low
        pulse_clear();
        expect_now("R3", SIG_STATUS, 0);
        ref_run = 1;
        wait_mon(40);
        expect_now("R3", SIG_STATUS, 0);

        // R5/R6/R7: failover with reference stopped high
        failover_en = 1; data_in = 4'h2;
        ref_idle = 1; ref_run = 0;
        wait_mon(30);
        expect_now("R5", SIG_ONRX, 1);
        expect_now("R3", SIG_STATUS, 1);
        expect_now("R6", SIG_DATA, 32'hF);
        wait_mon(30);
        clk_follows("R7", SIG_CLKRX);

        // R8: a short burst does not restore the reference
        ref_run = 1;
        #100;
        ref_run = 0;
        wait_mon(40);
        expect_now("R8", SIG_ONRX, 1);

        // R10: dropping the control releases at once
        failover_en = 0;
        wait_mon(2);
        expect_now("R10", SIG_ONRX, 0);
        expect_now("R10", SIG_DATA, 32'h2);
        failover_en = 1;
        wait_mon(2);
        expect_now("R5", SIG_ONRX, 1);
        wait_mon(40);

        // R8/R9: steady edges restore the reference; flag stays set
        ref_run = 1;
        wait_mon(8);
        expect_now("R8", SIG_ONRX, 1);
        wait_mon(32);
        expect_now("R8", SIG_ONRX, 0);
        expect_now("R9", SIG_STATUS, 1);
        data_in = 4'h9; wait_mon(1);
        expect_now("R11", SIG_DATA, 32'h9);
        wait_mon(60);
        clk_follows("R8", SIG_CLKREF);

        pulse_clear();
        expect_now("R3", SIG_STATUS, 0);

        done = 1;
        report();
    end
endmodule